// File: doc/BRIEF.md
# Split-Phase Internal Load Unit

This unit serves data reads from on-chip memory for a 16-bit processor core in two steps. A request instruction supplies a base register value and an offset. The unit adds them and drives the sum to the memories at once. A later retrieve instruction collects the word. The memories have a one-cycle synchronous read. The unit captures the returned word into a small in-order result queue one cycle after the request, so a retrieve issued two cycles after its request finds the word waiting. The core can issue a new request every cycle, and retrieves then drain the queue in request order.

The 16-bit data address space has two regions:

- Addresses with the top bit clear select a 16384-word code/data RAM. Only the low 14 bits index that RAM, so $4000–$7FFF reads the same words as $0000–$3FFF.
- Addresses with the top bit set select a control region, which takes the low 15 bits.

One region-select register follows the most recent request, and it steers the data of every read still in flight. Mixing regions among outstanding requests therefore returns words from whichever region was requested last. This is deliberate.

A stack pop request uses the same path. Its address is the stack pointer, which resets to $8000. A pop request moves the pointer up by one, and a push moves it down by one.

Top module: `split_load_unit`

## Requirements
- R1: A load request (`ld_req`=1) presents address `ld_base + ld_off` (mod 2^16) in the same cycle. In that cycle `rd_stb`=1, `ram_addr` carries the address bits [13:0], and `ctl_addr` carries the address bits [14:0]. With no request, `rd_stb`=0.
- R2: A retrieve (`rtv`=1) issued two cycles after a request returns that request's word on `rtv_data` in the same cycle, with `rtv_err`=0. A retrieve issued in the very next cycle after a request finds the queue empty.
- R3: Requests may be issued on consecutive cycles. Retrieves return the words in request order. The queue holds 4 words. A word that arrives while the queue is full, with no retrieve in that cycle, is discarded.
- R4: An address with bit 15 = 0 reads RAM word `addr[13:0]`, so addresses that differ only in bit 14 return the same word.
- R5: An address with bit 15 = 1 reads control word `addr[14:0]`.
- R6: The word captured for a pending request comes from the region of the newest request issued up to and including its capture cycle.
- R7: A pop request (`pop_req`=1 with `ld_req`=0) reads at the current stack pointer, queues its word like a load, and increments `sp` by one.
- R8: A push (`push_req`=1) decrements `sp` by one. Push and pop together leave `sp` unchanged. When a load and a pop arrive together, the load is served and the pop has no effect.
- R9: A retrieve on an empty queue gives `rtv_data`=0 and `rtv_err`=1. Whenever no retrieve is issued, `rtv_data` is 0 and `rtv_err` is 0.
- R10: After reset, `sp`=$8000, the queue is empty, and the region select points at RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_req | input | 1 | Load request |
| ld_base | input | 16 | Base register value |
| ld_off | input | 16 | Address offset |
| pop_req | input | 1 | Stack pop request |
| push_req | input | 1 | Stack push (pointer decrement) |
| rtv | input | 1 | Retrieve the oldest queued word |
| rtv_data | output | 16 | Retrieved word |
| rtv_err | output | 1 | Retrieve found the queue empty |
| sp | output | 16 | Stack pointer |
| rd_stb | output | 1 | Read strobe to both memories |
| ram_addr | output | 14 | Code/data RAM word address |
| ctl_addr | output | 15 | Control region word address |
| ram_rdata | input | 16 | RAM read data, one cycle after strobe |
| ctl_rdata | input | 16 | Control read data, one cycle after strobe |

## Verification
The bench targets several timing and steering cases:

- **Retrieve too early.** A retrieve issued one cycle after its request must report empty. A design that forwards the word a cycle early, or a cycle late, fails this or the two-cycle case.
- **Mixed regions.** Requests to both regions issued back to back must return every pending word from the last region. A design that latches a select per request returns correct-looking data here and is flagged.
- **Mirror and overflow.** Mirror addresses and a fifth unretrieved word check the RAM index width and the queue drop rule.
- **Stack pointer collisions.** Pop combined with load or push checks the pointer arithmetic.

// File: rtl/sl_pkg.sv
// Package: shared types for the split-phase load unit.
// Assumes: one region bit (address MSB) chooses between two read sources.
package sl_pkg;
    typedef enum logic {
        REG_RAM = 1'b0,
        REG_CTL = 1'b1
    } region_e;
endpackage

// File: rtl/sl_addr_gen.sv
// Module: sl_addr_gen
// Forms the read address for this cycle from either a load (base+offset)
// or a pop (stack pointer). A load wins over a simultaneous pop.
// Assumes: region is chosen by the address MSB.
module sl_addr_gen
    import sl_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          ld_req,
    input  logic [AW-1:0] ld_base,
    input  logic [AW-1:0] ld_off,
    input  logic          pop_req,
    input  logic [AW-1:0] sp,
    output logic          issue,
    output logic          pop_take,
    output logic [AW-1:0] addr,
    output region_e       region
);
    // Select the address source and decode its region.
    always_comb begin
        pop_take = pop_req && !ld_req;
        issue    = ld_req || pop_req;
        addr     = ld_req ? (ld_base + ld_off) : sp;
        region   = region_e'(addr[AW-1]);
    end
endmodule

// File: rtl/sl_stack_ptr.sv
// Module: sl_stack_ptr
// Holds the stack pointer. It goes up on an accepted pop and down on a
// push, and both together cancel.
// Assumes: a pop reads at the pointer value before its increment.
module sl_stack_ptr #(
    parameter int          AW       = 16,
    parameter logic [AW-1:0] SP_RESET = 16'h8000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_take,
    input  logic          push,
    output logic [AW-1:0] sp
);
    // Update the pointer from the pop/push pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= SP_RESET;
        end else begin
            case ({pop_take, push})
                2'b10:   sp <= sp + 1'b1;
                2'b01:   sp <= sp - 1'b1;
                default: sp <= sp;
            endcase
        end
    end

    a_r10_sp_reset: assert property (@(posedge clk) !rst_n |=> sp == SP_RESET);
    a_r7_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_take && !push) |=> sp == $past(sp) + 1'b1);
    a_r8_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop_take) |=> sp == $past(sp) - 1'b1);
endmodule

// File: rtl/sl_result_fifo.sv
// Module: sl_result_fifo
// In-order result queue with a combinational head. A write into a full
// queue succeeds only if a read frees a slot in the same cycle.
// Otherwise the word is dropped.
// Assumes: DEPTH >= 2.
module sl_result_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          rd_en,
    output logic [DW-1:0] head,
    output logic          empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          full, do_rd, do_wr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Derive occupancy flags and the accepted operations.
    always_comb begin
        empty = (cnt == '0);
        full  = (cnt == CW'(DEPTH));
        do_rd = rd_en && !empty;
        do_wr = wr_en && (!full || do_rd);
        head  = mem[rd_ptr];
    end

    // Advance pointers, count and storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_wr) begin
                mem[wr_ptr] <= wdata;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_rd) rd_ptr <= bump(rd_ptr);
            cnt <= cnt + CW'(do_wr) - CW'(do_rd);
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    a_r3_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !full) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/split_load_unit.sv
// Module: split_load_unit (top)
// Split-phase internal read unit. The address goes out in the request
// cycle, the memories answer one cycle later, and the word is pushed into
// the queue at the end of that cycle, ready for a retrieve two cycles
// after the request. A single region select follows the newest request
// and steers every capture.
// Assumes: both memories have a one-cycle synchronous read on rd_stb.
module split_load_unit
    import sl_pkg::*;
#(
    parameter int            DW        = 16,
    parameter int            AW        = 16,
    parameter int            RAM_WORDS = 16384,
    parameter int            DEPTH     = 4,
    parameter logic [AW-1:0] SP_RESET  = 16'h8000,
    localparam int           RAM_AW    = $clog2(RAM_WORDS),
    localparam int           CTL_AW    = AW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req,
    input  logic [AW-1:0]     ld_base,
    input  logic [AW-1:0]     ld_off,
    input  logic              pop_req,
    input  logic              push_req,
    input  logic              rtv,
    output logic [DW-1:0]     rtv_data,
    output logic              rtv_err,
    output logic [AW-1:0]     sp,
    output logic              rd_stb,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [CTL_AW-1:0] ctl_addr,
    input  logic [DW-1:0]     ram_rdata,
    input  logic [DW-1:0]     ctl_rdata
);
    logic          issue, pop_take;
    logic [AW-1:0] addr;
    region_e       region, cs_q, cs_eff;
    logic          pend_q;
    logic [DW-1:0] cap_data, head;
    logic          empty;

    sl_addr_gen #(.AW(AW)) i_addr (
        .ld_req(ld_req), .ld_base(ld_base), .ld_off(ld_off),
        .pop_req(pop_req), .sp(sp), .issue(issue), .pop_take(pop_take),
        .addr(addr), .region(region)
    );

    sl_stack_ptr #(.AW(AW), .SP_RESET(SP_RESET)) i_sp (
        .clk(clk), .rst_n(rst_n), .pop_take(pop_take), .push(push_req), .sp(sp)
    );

    // Drive the memory read port and pick the region for this cycle's capture.
    always_comb begin
        rd_stb   = issue;
        ram_addr = addr[RAM_AW-1:0];
        ctl_addr = addr[CTL_AW-1:0];
        cs_eff   = issue ? region : cs_q;
        cap_data = (cs_eff == REG_CTL) ? ctl_rdata : ram_rdata;
    end

    // Track the read in flight and the most recent region select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cs_q   <= REG_RAM;
        end else begin
            pend_q <= issue;
            cs_q   <= cs_eff;
        end
    end

    sl_result_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(pend_q), .wdata(cap_data),
        .rd_en(rtv), .head(head), .empty(empty)
    );

    // Present the queue head on a retrieve, or zero with error if empty.
    always_comb begin
        rtv_err  = rtv && empty;
        rtv_data = (rtv && !empty) ? head : '0;
    end

    a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rtv_err |-> (rtv_data == '0));
    a_r2_early_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && empty && !pend_q) |=> (!rtv || rtv_err));
    a_r1_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb == (ld_req || pop_req));
endmodule

// File: tb/test_split_load_unit.sv
module test_split_load_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_req = 0, pop_req = 0, push_req = 0, rtv = 0;
    logic [15:0] ld_base = '0, ld_off = '0;
    logic [15:0] rtv_data, sp, ram_rdata, ctl_rdata;
    logic        rtv_err, rd_stb;
    logic [13:0] ram_addr;
    logic [14:0] ctl_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    split_load_unit i_split_load_unit (
        .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_base(ld_base),
        .ld_off(ld_off), .pop_req(pop_req), .push_req(push_req), .rtv(rtv),
        .rtv_data(rtv_data), .rtv_err(rtv_err), .sp(sp), .rd_stb(rd_stb),
        .ram_addr(ram_addr), .ctl_addr(ctl_addr), .ram_rdata(ram_rdata),
        .ctl_rdata(ctl_rdata)
    );

    function automatic logic [15:0] ram_fn(input logic [13:0] a);
        return 16'({2'b00, a} * 16'd7 + 16'h1357);
    endfunction
    function automatic logic [15:0] ctl_fn(input logic [14:0] a);
        return 16'({1'b0, a} * 16'd13) ^ 16'hC0DE;
    endfunction

    // Environment memories: synchronous one-cycle read.
    always @(posedge clk) begin
        if (rd_stb) begin
            ram_rdata <= ram_fn(ram_addr);
            ctl_rdata <= ctl_fn(ctl_addr);
        end
    end

    // Reference model state.
    logic [15:0] q[$];
    logic [15:0] m_sp = 16'h8000;
    logic        m_cs = 1'b0;
    logic        m_pend = 1'b0;
    logic [15:0] m_paddr = '0;

    task automatic chk(input logic ok, input string tg, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tg, act, exp, $time);
        end
    endtask

    // One clock: drive, compare against the model, then advance the model.
    task automatic step(input logic l, input logic [15:0] b, input logic [15:0] o,
                        input logic p, input logic u, input logic r, input string tg);
        logic        iss, reg_now, cs_l;
        logic [15:0] a, word;
        @(negedge clk);
        ld_req = l; ld_base = b; ld_off = o; pop_req = p; push_req = u; rtv = r;
        iss = l || p;
        a = l ? 16'(b + o) : m_sp;
        reg_now = a[15];
        #2;
        chk(sp == m_sp, {tg, " R7 R8 sp"}, sp, m_sp);
        chk(rd_stb == iss, {tg, " R1 strobe"}, {15'd0, rd_stb}, {15'd0, iss});
        if (iss) begin
            chk(ram_addr == a[13:0], {tg, " R1 R4 ram_addr"}, {2'b0, ram_addr}, {2'b0, a[13:0]});
            chk(ctl_addr == a[14:0], {tg, " R1 R5 ctl_addr"}, {1'b0, ctl_addr}, {1'b0, a[14:0]});
        end
        if (r && q.size() == 0) begin
            chk(rtv_err == 1'b1, {tg, " R9 err"}, {15'd0, rtv_err}, 16'd1);
            chk(rtv_data == 16'd0, {tg, " R9 zero"}, rtv_data, 16'd0);
        end else if (r) begin
            chk(rtv_err == 1'b0, {tg, " R2 no err"}, {15'd0, rtv_err}, 16'd0);
            chk(rtv_data == q[0], {tg, " R2 R3 data"}, rtv_data, q[0]);
        end else begin
            chk(rtv_err == 1'b0 && rtv_data == 16'd0, {tg, " R9 idle"}, rtv_data, 16'd0);
        end
        cs_l = iss ? reg_now : m_cs;
        word = cs_l ? ctl_fn(m_paddr[14:0]) : ram_fn(m_paddr[13:0]);
        @(posedge clk);
        if (r && q.size() != 0) void'(q.pop_front());
        if (m_pend && q.size() < 4) q.push_back(word);
        m_pend = iss; m_paddr = a; m_cs = cs_l;
        if (p && !l && !u) m_sp = m_sp + 1;
        else if (u && !(p && !l)) m_sp = m_sp - 1;
    endtask

    task automatic idle(input int n, input string tg);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tg);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state: sp, empty queue
        idle(1, "R10 reset");
        step(0, 0, 0, 0, 0, 1, "R10 empty queue");
        // R2: retrieve two cycles after a request; one cycle is too early
        step(1, 16'h0100, 16'h0023, 0, 0, 0, "R2 req");
        idle(1, "R2 gap");
        step(0, 0, 0, 0, 0, 1, "R2 on time");
        step(1, 16'h0200, 16'h0001, 0, 0, 0, "R2 req early");
        step(0, 0, 0, 0, 0, 1, "R2 too early");
        idle(1, "R2 drain0");
        step(0, 0, 0, 0, 0, 1, "R2 drain");
        // R3: burst of five, the fifth dropped
        for (int i = 0; i < 5; i++) step(1, 16'h0040, 16'(i), 0, 0, 0, "R3 burst");
        idle(2, "R3 wait");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1, "R3 in order");
        // R4 mirror and R5 control region
        step(1, 16'h4000, 16'h0005, 0, 0, 0, "R4 mirror");
        step(1, 16'h0000, 16'h0005, 0, 0, 0, "R4 base");
        step(1, 16'h8000, 16'h0123, 0, 0, 1, "R5 ctl");
        step(0, 0, 0, 0, 0, 1, "R4 R5 rd");
        step(0, 0, 0, 0, 0, 1, "R4 R5 rd");
        step(0, 0, 0, 0, 0, 1, "R5 rd");
        // R6: mixed regions, last select wins
        step(1, 16'h0010, 0, 0, 0, 0, "R6 ram req");
        step(1, 16'h8020, 0, 0, 0, 0, "R6 ctl req");
        idle(1, "R6 gap");
        step(0, 0, 0, 0, 0, 1, "R6 rd");
        step(0, 0, 0, 0, 0, 1, "R6 rd");
        // R7 pops, R8 push and collisions
        step(0, 0, 0, 1, 0, 0, "R7 pop");
        step(0, 0, 0, 1, 0, 0, "R7 pop");
        step(0, 0, 0, 0, 1, 1, "R8 push");
        step(0, 0, 0, 1, 1, 1, "R8 push+pop");
        step(1, 16'h0300, 16'h0003, 1, 0, 1, "R8 ld over pop");
        idle(1, "R8 gap");
        step(0, 0, 0, 0, 0, 1, "R8 rd");
        step(0, 0, 0, 0, 0, 1, "R9 empty");
        // Mixed random traffic
        for (int i = 0; i < 400; i++)
            step(1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
                 1'($urandom_range(0, 1)), "R1 R3 R6 R7 random");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule